// File: doc/BRIEF.md
# Thread-Context Ring Matcher

This block sits in an interrupt presenter, one copy per hardware thread. It decides whether an incoming notification is aimed at its thread and, if so, at which privilege ring. A notification carries five things: a format bit, an ignore bit, a target block id, a 24-bit virtual-processor index and a logical-server number. The block compares these with word 2 of the thread's four ring context registers (physical, pool, OS and user). It also uses the thread's own block id and processor id.

Word 2 of each ring arrives in memory byte order, with the most significant byte first, and is byte-swapped before use. The physical ring has no stored CAM field. It is compared against a hardware CAM line built from the block id and the low bits of the processor id. A configuration bit selects a 7-bit or an 8-bit thread field for that line.

A request strobe samples all inputs. One clock later the block pulses `done_o` and presents a match flag, the matched ring and an "unsupported" flag. It holds these until the next request.

Top module: `ctx_ring_matcher`

## Requirements
- R1: While `rst_n` is low, `done_o`, `hit_o`, `ring_o` and `unsup_o` are all 0.
- R2: A cycle with `req_i` high produces a one-cycle `done_o` pulse in the next cycle. The results update in that same cycle. With `req_i` low, `hit_o`, `ring_o` and `unsup_o` keep their values.
- R3: The 31-bit target CAM line is the target block id in bits [30:24] and the target index in bits [23:0].
- R4: With `tid8_i`=0, the hardware CAM line has the thread's block id in [30:24] and bit 7 set. Bits [6:0] hold `proc_id_i[6:0]` and all other bits are 0. For example, processor id 0x93 gives index 0x000093.
- R5: With `tid8_i`=1, the hardware CAM line has bit 8 set and bits [7:0] equal to `proc_id_i[7:0]`. All other bits of the index part are 0. For example, processor id 0x93 gives index 0x000193.
- R6: Each ring word input carries the byte at the lowest memory address in bits [7:0]. The logical word is that input with its four bytes reversed.
- R7: In each logical word, bit 31 is the valid bit. Bits [30:0] are the CAM field for the pool and OS rings. Bits [23:0] are the logical-server field for the user ring, and user bits [30:24] have no effect.
- R8: With format 0 and ignore 0, the rings are checked in a fixed order: physical (ring code 2'b11), then pool (2'b10), then OS (2'b01). The first valid ring whose CAM equals the target wins. Physical compares against the hardware CAM line; pool and OS compare against their stored fields.
- R9: With format 0 and ignore 1, the result is no match with `unsup_o`=1, whatever the ring words hold.
- R10: With format 1, the result is the user ring (2'b00) only when four conditions all hold: OS valid is set, the OS CAM equals the target, user valid is set, and the user logical-server field equals `lserv_i`. The physical and pool words have no effect.
- R11: With no match, `hit_o`=0 and `ring_o`=2'b00. `unsup_o` is 0 unless R9 applies.
- R12: A ring whose valid bit is clear never matches, even if its CAM equals the target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, samples all inputs |
| fmt_i | input | 1 | Notification format (0 specific, 1 user branch) |
| ignore_i | input | 1 | Ignore bit (group request when format is 0) |
| tgt_blk_i | input | 7 | Target block id |
| tgt_idx_i | input | 24 | Target virtual-processor index |
| lserv_i | input | 24 | Logical-server number |
| own_blk_i | input | 7 | Block id of this thread's controller |
| proc_id_i | input | 8 | Processor id of this thread |
| tid8_i | input | 1 | 1 selects 8-bit thread field, 0 the 7-bit field |
| phys_w2_i | input | 32 | Physical ring word 2, memory byte order |
| pool_w2_i | input | 32 | Pool ring word 2, memory byte order |
| os_w2_i | input | 32 | OS ring word 2, memory byte order |
| user_w2_i | input | 32 | User ring word 2, memory byte order |
| done_o | output | 1 | One-cycle pulse, result ready |
| hit_o | output | 1 | Notification matched a ring |
| ring_o | output | 2 | Matched ring code |
| unsup_o | output | 1 | Unsupported group request seen |

## Verification
Any wrong internal state shows on `hit_o`, `ring_o` or `unsup_o` in the cycle right after the request that exposes it. A byte swap wired wrongly, a misplaced thread bit in the hardware CAM line or a swapped priority arm each give a wrong ring or a lost match on that first result. A stale result register or a missing clock enable shows as a value that changes during idle cycles, or as a `done_o` pulse one cycle off. The bench compares every result against a model that keeps its own copy of the priority order.

// File: rtl/ctx_match_pkg.sv
package ctx_match_pkg;

  typedef enum logic [1:0] {
    RING_USER = 2'b00,
    RING_OS   = 2'b01,
    RING_POOL = 2'b10,
    RING_PHYS = 2'b11
  } ring_e;

  localparam int NUM_RINGS = 4;

  typedef struct packed {
    logic  hit;
    ring_e ring;
    logic  unsup;
  } match_res_t;

endpackage

// File: rtl/ring_word_unpack.sv
// Restores host order of one ring word and splits valid bit and field.
module ring_word_unpack #(
  parameter int WORD_W  = 32,
  parameter int FIELD_W = 31
) (
  input  logic [WORD_W-1:0]  raw_i,
  output logic               valid_o,
  output logic [FIELD_W-1:0] field_o
);
  localparam int NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] host;

  generate
    for (genvar b = 0; b < NBYTES; b++) begin : g_swap
      assign host[8*b +: 8] = raw_i[WORD_W-8*(b+1) +: 8];
    end
  endgenerate

  assign valid_o = host[WORD_W-1];
  assign field_o = host[FIELD_W-1:0];
endmodule

// File: rtl/cam_line_build.sv
// Forms the target CAM line and the thread's hardware CAM line.
module cam_line_build #(
  parameter int BLK_W = 7,
  parameter int IDX_W = 24,
  parameter int PID_W = 8
) (
  input  logic [BLK_W-1:0]       tgt_blk_i,
  input  logic [IDX_W-1:0]       tgt_idx_i,
  input  logic [BLK_W-1:0]       own_blk_i,
  input  logic [PID_W-1:0]       proc_id_i,
  input  logic                   tid8_i,
  output logic [BLK_W+IDX_W-1:0] tgt_cam_o,
  output logic [BLK_W+IDX_W-1:0] hw_cam_o
);
  localparam int TID_NARROW = 7;
  localparam int TID_WIDE   = 8;

  logic [IDX_W-1:0] hw_idx;

  always_comb begin
    hw_idx = '0;
    if (tid8_i) begin
      hw_idx[TID_WIDE]     = 1'b1;
      hw_idx[TID_WIDE-1:0] = proc_id_i[TID_WIDE-1:0];
    end else begin
      hw_idx[TID_NARROW]     = 1'b1;
      hw_idx[TID_NARROW-1:0] = proc_id_i[TID_NARROW-1:0];
    end
  end

  assign tgt_cam_o = {tgt_blk_i, tgt_idx_i};
  assign hw_cam_o  = {own_blk_i, hw_idx};
endmodule

// File: rtl/ring_select.sv
// Per-ring match terms and the fixed priority choice.
module ring_select
  import ctx_match_pkg::*;
#(
  parameter int CAM_W = 31,
  parameter int LS_W  = 24
) (
  input  logic             fmt_i,
  input  logic             ignore_i,
  input  logic [CAM_W-1:0] tgt_cam_i,
  input  logic [CAM_W-1:0] hw_cam_i,
  input  logic [LS_W-1:0]  lserv_i,
  input  logic             phys_v_i,
  input  logic             pool_v_i,
  input  logic [CAM_W-1:0] pool_cam_i,
  input  logic             os_v_i,
  input  logic [CAM_W-1:0] os_cam_i,
  input  logic             user_v_i,
  input  logic [LS_W-1:0]  user_ls_i,
  output match_res_t       res_o
);
  logic phys_ok, pool_ok, os_ok, user_ok;

  assign phys_ok = phys_v_i && (hw_cam_i == tgt_cam_i);
  assign pool_ok = pool_v_i && (pool_cam_i == tgt_cam_i);
  assign os_ok   = os_v_i && (os_cam_i == tgt_cam_i);
  assign user_ok = os_ok && user_v_i && (user_ls_i == lserv_i);

  always_comb begin
    res_o = '{hit: 1'b0, ring: RING_USER, unsup: 1'b0};
    if (fmt_i) begin
      if (user_ok) begin
        res_o.hit  = 1'b1;
        res_o.ring = RING_USER;
      end
    end else if (ignore_i) begin
      res_o.unsup = 1'b1;
    end else if (phys_ok) begin
      res_o.hit  = 1'b1;
      res_o.ring = RING_PHYS;
    end else if (pool_ok) begin
      res_o.hit  = 1'b1;
      res_o.ring = RING_POOL;
    end else if (os_ok) begin
      res_o.hit  = 1'b1;
      res_o.ring = RING_OS;
    end
  end
endmodule

// File: rtl/ctx_ring_matcher.sv
module ctx_ring_matcher
  import ctx_match_pkg::*;
#(
  parameter int BLK_W  = 7,
  parameter int IDX_W  = 24,
  parameter int PID_W  = 8,
  parameter int LS_W   = 24,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              fmt_i,
  input  logic              ignore_i,
  input  logic [BLK_W-1:0]  tgt_blk_i,
  input  logic [IDX_W-1:0]  tgt_idx_i,
  input  logic [LS_W-1:0]   lserv_i,
  input  logic [BLK_W-1:0]  own_blk_i,
  input  logic [PID_W-1:0]  proc_id_i,
  input  logic              tid8_i,
  input  logic [WORD_W-1:0] phys_w2_i,
  input  logic [WORD_W-1:0] pool_w2_i,
  input  logic [WORD_W-1:0] os_w2_i,
  input  logic [WORD_W-1:0] user_w2_i,
  output logic              done_o,
  output logic              hit_o,
  output logic [1:0]        ring_o,
  output logic              unsup_o
);
  localparam int CAM_W = BLK_W + IDX_W;

  logic [CAM_W-1:0]  tgt_cam, hw_cam;
  logic [WORD_W-1:0] raw_w   [NUM_RINGS];
  logic              ring_v  [NUM_RINGS];
  logic [CAM_W-1:0]  ring_f  [NUM_RINGS];
  logic [CAM_W-1:0]  phys_cam_unused;
  logic [CAM_W-LS_W-1:0] user_hi_unused;

  match_res_t res_d, res_q, res_nxt;
  logic       done_q, done_nxt;

  cam_line_build #(.BLK_W(BLK_W), .IDX_W(IDX_W), .PID_W(PID_W)) u_cam (
    .tgt_blk_i (tgt_blk_i),
    .tgt_idx_i (tgt_idx_i),
    .own_blk_i (own_blk_i),
    .proc_id_i (proc_id_i),
    .tid8_i    (tid8_i),
    .tgt_cam_o (tgt_cam),
    .hw_cam_o  (hw_cam)
  );

  assign raw_w[int'(RING_USER)] = user_w2_i;
  assign raw_w[int'(RING_OS)]   = os_w2_i;
  assign raw_w[int'(RING_POOL)] = pool_w2_i;
  assign raw_w[int'(RING_PHYS)] = phys_w2_i;

  generate
    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
      ring_word_unpack #(.WORD_W(WORD_W), .FIELD_W(CAM_W)) u_unpack (
        .raw_i   (raw_w[g]),
        .valid_o (ring_v[g]),
        .field_o (ring_f[g])
      );
    end
  endgenerate

  // The physical ring uses the derived line; user high bits are don't-care.
  assign phys_cam_unused = ring_f[int'(RING_PHYS)];
  assign user_hi_unused  = ring_f[int'(RING_USER)][CAM_W-1:LS_W];

  ring_select #(.CAM_W(CAM_W), .LS_W(LS_W)) u_sel (
    .fmt_i      (fmt_i),
    .ignore_i   (ignore_i),
    .tgt_cam_i  (tgt_cam),
    .hw_cam_i   (hw_cam),
    .lserv_i    (lserv_i),
    .phys_v_i   (ring_v[int'(RING_PHYS)]),
    .pool_v_i   (ring_v[int'(RING_POOL)]),
    .pool_cam_i (ring_f[int'(RING_POOL)]),
    .os_v_i     (ring_v[int'(RING_OS)]),
    .os_cam_i   (ring_f[int'(RING_OS)]),
    .user_v_i   (ring_v[int'(RING_USER)]),
    .user_ls_i  (ring_f[int'(RING_USER)][LS_W-1:0]),
    .res_o      (res_d)
  );

  // Next state: result captured only on a request.
  always_comb begin
    done_nxt = req_i;
    res_nxt  = res_q;
    if (req_i) begin
      res_nxt = res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      res_q  <= '{hit: 1'b0, ring: RING_USER, unsup: 1'b0};
    end else begin
      done_q <= done_nxt;
      res_q  <= res_nxt;
    end
  end

  assign done_o  = done_q;
  assign hit_o   = res_q.hit;
  assign ring_o  = res_q.ring;
  assign unsup_o = res_q.unsup;

  // R2: pulse follows the request by one cycle; results hold while idle
  p_done_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> done_o);
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> ($stable(hit_o) && $stable(ring_o) && $stable(unsup_o)));
  // R9: group request is never a hit
  p_ignore_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !fmt_i && ignore_i) |=> (unsup_o && !hit_o));
  p_unsup_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_o |-> !hit_o);
  // R11: no hit reports ring code zero
  p_nohit_ring_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (ring_o == 2'b00));
  // R10: user-branch format only ever yields the user ring
  p_user_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && fmt_i) |=> (!unsup_o && (!hit_o || ring_o == RING_USER)));
  // R8: a valid physical ring with an equal hardware line always wins
  p_phys_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !fmt_i && !ignore_i && ring_v[int'(RING_PHYS)] && (hw_cam == tgt_cam))
    |=> (hit_o && ring_o == RING_PHYS));
endmodule

// File: tb/ctx_ring_matcher_test.sv
module ctx_ring_matcher_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0, fmt_i = 1'b0, ignore_i = 1'b0, tid8_i = 1'b0;
  logic [6:0]  tgt_blk_i = '0, own_blk_i = '0;
  logic [23:0] tgt_idx_i = '0, lserv_i = '0;
  logic [7:0]  proc_id_i = '0;
  logic [31:0] phys_w2_i = '0, pool_w2_i = '0, os_w2_i = '0, user_w2_i = '0;
  logic        done_o, hit_o, unsup_o;
  logic [1:0]  ring_o;

  ctx_ring_matcher uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .fmt_i(fmt_i), .ignore_i(ignore_i),
    .tgt_blk_i(tgt_blk_i), .tgt_idx_i(tgt_idx_i), .lserv_i(lserv_i),
    .own_blk_i(own_blk_i), .proc_id_i(proc_id_i), .tid8_i(tid8_i),
    .phys_w2_i(phys_w2_i), .pool_w2_i(pool_w2_i), .os_w2_i(os_w2_i),
    .user_w2_i(user_w2_i), .done_o(done_o), .hit_o(hit_o), .ring_o(ring_o),
    .unsup_o(unsup_o)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic       hit;
    logic [1:0] ring;
    logic       unsup;
    int         cyc;
    string      tag;
  } exp_t;

  exp_t  sb[$];
  exp_t  last_exp;
  int    n_cmp = 0, n_bad = 0, cyc = 0;
  bit    finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] to_mem(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic exp_t model(input logic f, input logic ig, input logic [6:0] blk,
      input logic [23:0] idx, input logic [23:0] ls, input logic [6:0] ob,
      input logic [7:0] pid, input logic t8, input logic [31:0] ph,
      input logic [31:0] po, input logic [31:0] os, input logic [31:0] us);
    exp_t e;
    logic [30:0] tgt, hw;
    logic [23:0] hidx;
    e.hit = 0; e.ring = 2'b00; e.unsup = 0; e.cyc = 0; e.tag = "";
    tgt  = {blk, idx};
    hidx = t8 ? (24'h100 | {16'h0, pid}) : (24'h80 | {17'h0, pid[6:0]});
    hw   = {ob, hidx};
    if (f) begin
      if (os[31] && os[30:0] == tgt && us[31] && us[23:0] == ls) begin
        e.hit = 1; e.ring = 2'b00;
      end
    end else if (ig) e.unsup = 1;
    else if (ph[31] && hw == tgt) begin e.hit = 1; e.ring = 2'b11; end
    else if (po[31] && po[30:0] == tgt) begin e.hit = 1; e.ring = 2'b10; end
    else if (os[31] && os[30:0] == tgt) begin e.hit = 1; e.ring = 2'b01; end
    return e;
  endfunction

  // Driver: ring words are given in logical order and sent in memory order.
  task automatic send(input string tag, input logic f, input logic ig,
      input logic [6:0] blk, input logic [23:0] idx, input logic [23:0] ls,
      input logic [6:0] ob, input logic [7:0] pid, input logic t8,
      input logic [31:0] ph, input logic [31:0] po, input logic [31:0] os,
      input logic [31:0] us);
    exp_t e;
    @(negedge clk);
    fmt_i = f; ignore_i = ig; tgt_blk_i = blk; tgt_idx_i = idx; lserv_i = ls;
    own_blk_i = ob; proc_id_i = pid; tid8_i = t8;
    phys_w2_i = to_mem(ph); pool_w2_i = to_mem(po);
    os_w2_i = to_mem(os); user_w2_i = to_mem(us);
    req_i = 1'b1;
    e = model(f, ig, blk, idx, ls, ob, pid, t8, ph, po, os, us);
    e.cyc = cyc; e.tag = tag;
    sb.push_back(e);
    last_exp = e;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  // Monitor: every queued item must be answered exactly one cycle later.
  always @(negedge clk) begin
    if (rst_n) begin
      if (sb.size() > 0 && cyc > sb[0].cyc) begin
        exp_t e;
        e = sb.pop_front();
        n_cmp++;
        if (!done_o || hit_o !== e.hit || ring_o !== e.ring || unsup_o !== e.unsup) begin
          n_bad++;
          $display("FAIL %s: done=%0b hit=%0b ring=%0d unsup=%0b expected done=1 hit=%0b ring=%0d unsup=%0b",
                   e.tag, done_o, hit_o, ring_o, unsup_o, e.hit, e.ring, e.unsup);
        end
      end else if (done_o) begin
        n_cmp++; n_bad++;
        $display("FAIL R2: done=1 expected done=0 (no request pending)");
      end
    end
  end

  task automatic check_hold(input string tag);
    repeat (3) @(negedge clk);
    n_cmp++;
    // R2: results kept across idle cycles with changed inputs
    if (done_o !== 1'b0 || hit_o !== last_exp.hit || ring_o !== last_exp.ring ||
        unsup_o !== last_exp.unsup) begin
      n_bad++;
      $display("FAIL %s: done=%0b hit=%0b ring=%0d unsup=%0b expected done=0 hit=%0b ring=%0d unsup=%0b",
               tag, done_o, hit_o, ring_o, unsup_o, last_exp.hit, last_exp.ring, last_exp.unsup);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    summary();
  end

  localparam logic [31:0] V = 32'h8000_0000;

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    // R1: reset state
    if (done_o !== 0 || hit_o !== 0 || ring_o !== 0 || unsup_o !== 0) begin
      n_bad++;
      $display("FAIL R1: done=%0b hit=%0b ring=%0d unsup=%0b expected all 0",
               done_o, hit_o, ring_o, unsup_o);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4: 7-bit thread field, pid 0x93 -> index 0x93, physical wins
    send("R4", 0, 0, 7'd5, 24'h000093, 0, 7'd5, 8'h93, 0, V, 0, 0, 0);
    // R5: 8-bit thread field, pid 0x93 -> index 0x193
    send("R5", 0, 0, 7'd5, 24'h000193, 0, 7'd5, 8'h93, 1, V, 0, 0, 0);
    send("R5", 0, 0, 7'd5, 24'h000093, 0, 7'd5, 8'h93, 1, V, 0, 0, 0);
    // R3: block id part must match too
    send("R3", 0, 0, 7'd6, 24'h000093, 0, 7'd5, 8'h93, 0, V, 0, 0, 0);
    // R8: all three match -> physical; then pool over OS; then OS alone
    send("R8", 0, 0, 7'd5, 24'h000093, 0, 7'd5, 8'h93, 0, V, V | 31'h0500_0093, V | 31'h0500_0093, 0);
    send("R8", 0, 0, 7'd2, 24'h123456, 0, 7'd5, 8'h93, 0, V, V | 31'h0212_3456, V | 31'h0212_3456, 0);
    send("R8", 0, 0, 7'd2, 24'h123456, 0, 7'd5, 8'h93, 0, V, V | 31'h0212_3457, V | 31'h0212_3456, 0);
    check_hold("R2");
    // R12: equal CAMs but valid clear
    send("R12", 0, 0, 7'd5, 24'h000093, 0, 7'd5, 8'h93, 0, 0, 31'h0500_0093, 31'h0500_0093, 0);
    // R9: group request with matching physical ring
    send("R9", 0, 1, 7'd5, 24'h000093, 0, 7'd5, 8'h93, 0, V, V | 31'h0500_0093, 0, 0);
    check_hold("R2");
    // R10: user branch, all four conditions, then each removed
    send("R10", 1, 0, 7'd3, 24'hABCDEF, 24'h00_0042, 7'd5, 8'h93, 0, 0, 0, V | 31'h03AB_CDEF, V | 32'h42);
    send("R10", 1, 0, 7'd3, 24'hABCDEF, 24'h00_0042, 7'd5, 8'h93, 0, 0, 0, 31'h03AB_CDEF, V | 32'h42);
    send("R10", 1, 0, 7'd3, 24'hABCDEF, 24'h00_0042, 7'd5, 8'h93, 0, 0, 0, V | 31'h03AB_CDEE, V | 32'h42);
    send("R10", 1, 0, 7'd3, 24'hABCDEF, 24'h00_0042, 7'd5, 8'h93, 0, 0, 0, V | 31'h03AB_CDEF, 32'h42);
    send("R10", 1, 0, 7'd3, 24'hABCDEF, 24'h00_0042, 7'd5, 8'h93, 0, 0, 0, V | 31'h03AB_CDEF, V | 32'h43);
    // R10: physical/pool contents have no effect in user format
    send("R10", 1, 1, 7'd5, 24'h000093, 24'h7, 7'd5, 8'h93, 0, V, V | 31'h0500_0093, 0, 0);
    // R7: user bits [30:24] are ignored
    send("R7", 1, 0, 7'd3, 24'hABCDEF, 24'h00_0042, 7'd5, 8'h93, 0, 0, 0, V | 31'h03AB_CDEF, V | 32'h7F00_0042);
    // R6: a word supplied without byte reversal must not match
    @(negedge clk);
    send("R6", 0, 0, 7'd2, 24'h123456, 0, 7'd5, 8'h93, 0, 0, to_mem(V | 31'h0212_3456), 0, 0);
    // R11: nothing matches
    send("R11", 0, 0, 7'd1, 24'h000001, 0, 7'd5, 8'h93, 0, V, V | 31'h2, V | 31'h3, 0);
    check_hold("R2");

    // Mixed patterns against the model (R8 R10 R11 R12)
    for (int i = 0; i < 300; i++) begin
      logic [6:0]  b;
      logic [23:0] x, l;
      logic [31:0] w [4];
      logic t8;
      b  = ($urandom % 2) ? 7'd5 : 7'($urandom);
      t8 = 1'($urandom);
      case ($urandom % 3)
        0: x = 24'h000093;
        1: x = 24'h000193;
        default: x = 24'($urandom);
      endcase
      l = 24'($urandom % 4);
      for (int k = 0; k < 4; k++) begin
        w[k] = ($urandom % 2) ? {1'($urandom), b, x} : $urandom;
      end
      w[3] = {1'($urandom), 7'($urandom), l};
      send("R8", 1'($urandom % 3 == 0), 1'($urandom % 5 == 0), b, x, 24'($urandom % 4),
           7'd5, 8'h93, t8, w[0], w[1], w[2], w[3]);
    end
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R2: %0d results missing, expected 0", sb.size());
    end
    summary();
  end
endmodule